// File: doc/BRIEF.md
# Retirement Event Commit Unit

This unit sits where instructions leave an in-order retirement stage. Each cycle it looks at the single instruction that is retiring and decides whether that instruction ends in a redirect. Three kinds of event can cause one. An abort is raised by the instruction itself. A trap is also raised by the instruction and comes as an overflow trap or a generic trap. The third is an external interrupt request, which is accepted at the boundary after the instruction. When an event is taken, the unit sends the front end a handler address and a one-cycle flush, and records the return pointer the handler must come back to. That pointer is chosen by the event kind. A trap resumes after the trapping instruction, or at the branch target when the trapping instruction was a taken transfer. An interrupt resumes at the next instruction in program order. A repeated string instruction that still has iterations left resumes at itself. An abort keeps the faulting PC for diagnosis only and is marked as not restartable.

Events come only from instructions that really retire. A slot that is not valid, or that is killed, never raises anything, whatever flags it carries. All outputs are registered. A redirect appears in the cycle after the retiring edge and lasts one cycle. The redirect port has no back-pressure: the front end must accept every redirect in the cycle it appears. After a redirect the unit ignores events until the first handler instruction retires.

Top module: `rtc_commit`

## Requirements
- R1: While reset is asserted, and after it is released, redirect, flush, restartable, cause, vector and return pointer all read 0 until the first event is taken.
- R2: A generic trap (trap=1, overflow=0) on a non-taken instruction gives cause 2, return pointer equal to the next sequential PC, and restartable=1.
- R3: A trap on an instruction with taken=1 saves the branch target as the return pointer instead of the next sequential PC.
- R4: A trap with overflow=1 gives cause 1, restartable=1, and the same return-pointer rules as R2 and R3.
- R5: An abort gives cause 3, saves the retiring instruction's own PC, and drives restartable=0.
- R6: When several events hit one retiring instruction, the abort wins over the trap and the trap wins over the interrupt. Exactly one redirect is issued.
- R7: An interrupt is taken (cause 0, restartable=1) only when the interrupt request and the enable are both 1 in a cycle with a valid, non-killed retirement. It saves the next PC in program order: the target when taken=1, otherwise the next sequential PC.
- R8: An interrupt taken on a repeated string instruction that still has iterations left (rep_more=1) saves that instruction's own PC.
- R9: A slot with valid=0 or kill=1 raises no event from its trap or abort flags. A request that is held high across such slots is taken at the next valid retirement.
- R10: The handler vector is VEC_BASE + cause*8. With the default base this gives 0x100 for the interrupt, 0x108 for the overflow trap, 0x110 for the generic trap and 0x118 for the abort.
- R11: Redirect and flush rise together in the cycle after the retiring edge and last exactly one cycle. No further redirect comes until the next valid, non-killed retirement, and that retirement raises no event itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_kill | input | 1 | The retiring slot was squashed and must not signal |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_next_pc | input | XLEN | Next sequential PC |
| ret_taken | input | 1 | Retiring instruction is a taken control transfer |
| ret_target | input | XLEN | Transfer destination |
| ret_trap | input | 1 | Instruction raised a trap |
| ret_trap_ovf | input | 1 | The trap is the overflow trap |
| ret_abort | input | 1 | Instruction raised an abort |
| ret_rep_more | input | 1 | Repeated string instruction with iterations remaining |
| irq_req | input | 1 | External interrupt request (level) |
| irq_en | input | 1 | Interrupt enable |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_vector | output | XLEN | Handler address |
| redir_ret_pc | output | XLEN | Saved return pointer |
| redir_cause | output | 2 | Event cause code |
| redir_restartable | output | 1 | 1 when the program can resume at the saved pointer |
| flush | output | 1 | One-cycle pipeline flush |

## Verification
The assertions assume that the retirement inputs are sampled only at rising edges and that the interrupt request is a level held by its source until it is served. They also assume the pipeline delivers at least one idle or killed slot before the handler's first instruction retires. The stimulus changes every input on the falling edge. It drives a valid=0 slot straight after each redirect and then a plain handler retirement, so every redirect is followed by the flush-and-restart sequence that a real front end produces. Checks in the hold cycle deliberately put event flags on that first handler retirement to show they are dropped.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ   = 2'd0,
    CAUSE_OVF   = 2'd1,
    CAUSE_TRAP  = 2'd2,
    CAUSE_ABORT = 2'd3
  } cause_e;

  typedef struct packed {
    logic   take;
    cause_e cause;
  } pick_t;
endpackage

// File: rtl/rtc_arbiter.sv
module rtc_arbiter
  import rtc_pkg::*;
(
  input  logic  retire_ok,
  input  logic  hold,
  input  logic  abort,
  input  logic  trap,
  input  logic  trap_ovf,
  input  logic  irq_req,
  input  logic  irq_en,
  output pick_t pick
);
  logic eligible;
  assign eligible = retire_ok & ~hold;

  always_comb begin
    pick.take  = 1'b0;
    pick.cause = CAUSE_IRQ;
    if (eligible) begin
      if (abort) begin
        pick.take  = 1'b1;
        pick.cause = CAUSE_ABORT;
      end else if (trap) begin
        pick.take  = 1'b1;
        pick.cause = trap_ovf ? CAUSE_OVF : CAUSE_TRAP;
      end else if (irq_req && irq_en) begin
        pick.take  = 1'b1;
        pick.cause = CAUSE_IRQ;
      end
    end
  end
endmodule

// File: rtl/rtc_resume.sv
module rtc_resume
  import rtc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cause_e            cause,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              taken,
  input  logic [XLEN-1:0]   target,
  input  logic              rep_more,
  output logic [XLEN-1:0]   ret_pc,
  output logic              restartable
);
  logic [XLEN-1:0] flow_pc;
  assign flow_pc = taken ? target : next_pc;

  always_comb begin
    unique case (cause)
      CAUSE_ABORT: begin
        ret_pc      = pc;
        restartable = 1'b0;
      end
      CAUSE_IRQ: begin
        ret_pc      = rep_more ? pc : flow_pc;
        restartable = 1'b1;
      end
      default: begin
        ret_pc      = flow_pc;
        restartable = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rtc_vector.sv
module rtc_vector
  import rtc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_BASE   = 'h100,
  parameter int unsigned     STRIDE_LOG = 3
) (
  input  cause_e          cause,
  output logic [XLEN-1:0] vector
);
  localparam int unsigned OFS_W = CAUSE_W + STRIDE_LOG;

  logic [OFS_W-1:0] offset;
  assign offset = {cause, {STRIDE_LOG{1'b0}}};
  assign vector = VEC_BASE + {{(XLEN-OFS_W){1'b0}}, offset};
endmodule

// File: rtl/rtc_commit.sv
module rtc_commit
  import rtc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_BASE   = 'h100,
  parameter int unsigned     STRIDE_LOG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ret_valid,
  input  logic                ret_kill,
  input  logic [XLEN-1:0]     ret_pc,
  input  logic [XLEN-1:0]     ret_next_pc,
  input  logic                ret_taken,
  input  logic [XLEN-1:0]     ret_target,
  input  logic                ret_trap,
  input  logic                ret_trap_ovf,
  input  logic                ret_abort,
  input  logic                ret_rep_more,
  input  logic                irq_req,
  input  logic                irq_en,
  output logic                redir_valid,
  output logic [XLEN-1:0]     redir_vector,
  output logic [XLEN-1:0]     redir_ret_pc,
  output logic [CAUSE_W-1:0]  redir_cause,
  output logic                redir_restartable,
  output logic                flush
);
  logic            retire_ok;
  logic            hold_q;
  pick_t           pick;
  logic [XLEN-1:0] nxt_ret_pc;
  logic            nxt_restart;
  logic [XLEN-1:0] nxt_vector;

  assign retire_ok = ret_valid & ~ret_kill;

  rtc_arbiter u_arb (
    .retire_ok (retire_ok),
    .hold      (hold_q),
    .abort     (ret_abort),
    .trap      (ret_trap),
    .trap_ovf  (ret_trap_ovf),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .pick      (pick)
  );

  rtc_resume #(.XLEN(XLEN)) u_res (
    .cause       (pick.cause),
    .pc          (ret_pc),
    .next_pc     (ret_next_pc),
    .taken       (ret_taken),
    .target      (ret_target),
    .rep_more    (ret_rep_more),
    .ret_pc      (nxt_ret_pc),
    .restartable (nxt_restart)
  );

  rtc_vector #(.XLEN(XLEN), .VEC_BASE(VEC_BASE), .STRIDE_LOG(STRIDE_LOG)) u_vec (
    .cause  (pick.cause),
    .vector (nxt_vector)
  );

  // Hold off redirects from the taken event until the first handler retirement.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (pick.take) begin
      hold_q <= 1'b1;
    end else if (retire_ok) begin
      hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid       <= 1'b0;
      flush             <= 1'b0;
      redir_vector      <= '0;
      redir_ret_pc      <= '0;
      redir_cause       <= '0;
      redir_restartable <= 1'b0;
    end else begin
      redir_valid <= pick.take;
      flush       <= pick.take;
      if (pick.take) begin
        redir_vector      <= nxt_vector;
        redir_ret_pc      <= nxt_ret_pc;
        redir_cause       <= pick.cause;
        redir_restartable <= nxt_restart;
      end
    end
  end
endmodule

// File: rtl/rtc_commit_chk.sv
module rtc_commit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic            ret_kill,
  input logic            ret_taken,
  input logic [XLEN-1:0] ret_target,
  input logic            ret_trap,
  input logic            ret_abort,
  input logic            irq_req,
  input logic            irq_en,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_ret_pc,
  input logic [1:0]      redir_cause,
  input logic            redir_restartable,
  input logic            flush
);
  AST_REDIR_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(ret_valid && !ret_kill)); // R9

  AST_ABORT_NOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_cause == 2'd3) |-> !redir_restartable); // R5

  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && $past(ret_abort)) |-> redir_cause == 2'd3); // R6

  AST_TRAP_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && $past(ret_trap && !ret_abort)) |-> (redir_cause == 2'd1 || redir_cause == 2'd2)); // R6

  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_cause != 2'd3 && redir_cause != 2'd0 && $past(ret_taken))
      |-> redir_ret_pc == $past(ret_target)); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_cause == 2'd0) |-> $past(irq_req && irq_en)); // R7

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush && !redir_valid); // R11

  AST_FLUSH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) |-> $rose(flush)); // R11
endmodule

bind rtc_commit rtc_commit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rtc_commit_test.sv
module rtc_commit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_valid = 0, ret_kill = 0, ret_taken = 0, ret_trap = 0;
  logic ret_trap_ovf = 0, ret_abort = 0, ret_rep_more = 0, irq_req = 0, irq_en = 0;
  logic [XLEN-1:0] ret_pc = '0, ret_next_pc = '0, ret_target = '0;
  logic redir_valid, redir_restartable, flush;
  logic [XLEN-1:0] redir_vector, redir_ret_pc;
  logic [1:0] redir_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]      cause;
    logic [XLEN-1:0] vec;
    logic [XLEN-1:0] rpc;
    logic            rst;
    string           tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  rtc_commit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kill(ret_kill),
    .ret_pc(ret_pc), .ret_next_pc(ret_next_pc), .ret_taken(ret_taken),
    .ret_target(ret_target), .ret_trap(ret_trap), .ret_trap_ovf(ret_trap_ovf),
    .ret_abort(ret_abort), .ret_rep_more(ret_rep_more), .irq_req(irq_req),
    .irq_en(irq_en), .redir_valid(redir_valid), .redir_vector(redir_vector),
    .redir_ret_pc(redir_ret_pc), .redir_cause(redir_cause),
    .redir_restartable(redir_restartable), .flush(flush)
  );

  task automatic expect_ev(input logic [1:0] c, input logic [XLEN-1:0] rpc,
                           input logic rs, input string tag);
    exp_t e;
    e.cause = c;
    e.vec   = 32'h100 + 32'(c) * 8;
    e.rpc   = rpc;
    e.rst   = rs;
    e.tag   = tag;
    expq.push_back(e);
  endtask

  // One retirement slot, driven on the falling edge.
  task automatic slot(input logic vl, input logic kl, input logic [XLEN-1:0] pc,
                      input logic tk, input logic [XLEN-1:0] tgt, input logic tr,
                      input logic ov, input logic ab, input logic rp);
    @(negedge clk);
    ret_valid = vl; ret_kill = kl; ret_pc = pc; ret_next_pc = pc + 4;
    ret_taken = tk; ret_target = tgt; ret_trap = tr; ret_trap_ovf = ov;
    ret_abort = ab; ret_rep_more = rp;
  endtask

  task automatic idle();
    slot(0, 0, '0, 0, '0, 0, 0, 0, 0);
  endtask

  // Flush bubble then the first handler instruction, which must raise nothing.
  task automatic recover();
    idle();
    slot(1, 0, 32'h100, 0, '0, 0, 0, 0, 0);
    idle();
  endtask

  // Monitor: compares each redirect against the scoreboard.
  logic prev_flush = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (flush !== redir_valid) begin
        checks++; errors++;
        $display("FAIL R11 flush=%0b redir_valid=%0b expected equal", flush, redir_valid);
      end
      if (prev_flush && flush) begin
        checks++; errors++;
        $display("FAIL R11 flush high two cycles: got 1 expected 0");
      end
      if (redir_valid) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R9/R11 unexpected redirect cause=%0d ret=%h expected none",
                   redir_cause, redir_ret_pc);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (redir_cause !== e.cause || redir_vector !== e.vec ||
              redir_ret_pc !== e.rpc || redir_restartable !== e.rst) begin
            errors++;
            $display("FAIL %s got cause=%0d vec=%h ret=%h rs=%0b expected cause=%0d vec=%h ret=%h rs=%0b",
                     e.tag, redir_cause, redir_vector, redir_ret_pc, redir_restartable,
                     e.cause, e.vec, e.rpc, e.rst);
          end
        end
      end
      prev_flush = flush;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (redir_valid !== 0 || flush !== 0 || redir_vector !== 0 || redir_ret_pc !== 0 ||
        redir_cause !== 0 || redir_restartable !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs got v=%0b f=%0b vec=%h ret=%h expected all 0",
               redir_valid, flush, redir_vector, redir_ret_pc);
    end
    @(negedge clk); rst_n = 1;
    idle(); idle();
    checks++;
    if (redir_valid !== 0 || redir_cause !== 0 || redir_ret_pc !== 0) begin
      errors++;
      $display("FAIL R1 after release got v=%0b expected 0", redir_valid);
    end

    // R2 / R10: generic trap
    expect_ev(2, 32'h1004, 1, "R2_R10 generic trap");
    slot(1, 0, 32'h1000, 0, 32'h9000, 1, 0, 0, 0); recover();
    // R3: trap on taken transfer
    expect_ev(2, 32'h2000, 1, "R3 trap on taken branch");
    slot(1, 0, 32'h1100, 1, 32'h2000, 1, 0, 0, 0); recover();
    // R4: overflow trap
    expect_ev(1, 32'h1204, 1, "R4 overflow trap");
    slot(1, 0, 32'h1200, 0, 32'h0, 1, 1, 0, 0); recover();
    expect_ev(1, 32'h2400, 1, "R4 overflow trap taken");
    slot(1, 0, 32'h1300, 1, 32'h2400, 1, 1, 0, 0); recover();
    // R5: abort
    expect_ev(3, 32'h3000, 0, "R5 abort saves pc");
    slot(1, 0, 32'h3000, 1, 32'h3800, 0, 0, 1, 0); recover();

    // R6: priorities with interrupt pending
    irq_en = 1; irq_req = 1;
    expect_ev(3, 32'h3100, 0, "R6 abort over trap and irq");
    slot(1, 0, 32'h3100, 0, 32'h0, 1, 0, 1, 0); recover();
    expect_ev(2, 32'h3204, 1, "R6 trap over irq");
    slot(1, 0, 32'h3200, 0, 32'h0, 1, 0, 0, 0);
    idle(); irq_req = 0;
    slot(1, 0, 32'h100, 0, '0, 0, 0, 0, 0); idle();

    // R7: enable low blocks interrupt
    irq_en = 0; irq_req = 1;
    slot(1, 0, 32'h3300, 0, 32'h0, 0, 0, 0, 0); idle(); idle();
    // R9: invalid and killed slots raise nothing; request stays pending
    irq_en = 1;
    idle(); idle();
    slot(1, 1, 32'h3400, 0, 32'h0, 1, 0, 1, 0); idle();
    slot(0, 0, 32'h3500, 0, 32'h0, 1, 1, 1, 0); idle();
    expect_ev(0, 32'h4004, 1, "R7_R9 pending irq at valid retire");
    slot(1, 0, 32'h4000, 0, 32'h0, 0, 0, 0, 0);
    idle(); irq_req = 0;
    slot(1, 0, 32'h100, 0, '0, 0, 0, 0, 0); idle();
    // R7: interrupt after taken branch
    irq_req = 1;
    expect_ev(0, 32'h4800, 1, "R7 irq after taken branch");
    slot(1, 0, 32'h4100, 1, 32'h4800, 0, 0, 0, 0);
    idle(); irq_req = 0;
    slot(1, 0, 32'h100, 0, '0, 0, 0, 0, 0); idle();
    // R8: repeated string mid-iteration
    irq_req = 1;
    expect_ev(0, 32'h5000, 1, "R8 irq mid repeat");
    slot(1, 0, 32'h5000, 0, 32'h0, 0, 0, 0, 1);
    idle(); irq_req = 0;
    slot(1, 0, 32'h100, 0, '0, 0, 0, 0, 0); idle();

    // R11: first handler retirement carries a trap and is dropped
    expect_ev(2, 32'h6004, 1, "R11 first trap");
    slot(1, 0, 32'h6000, 0, 32'h0, 1, 0, 0, 0);
    slot(1, 0, 32'h100, 0, 32'h0, 1, 0, 1, 0);
    idle();
    expect_ev(1, 32'h6104, 1, "R11 trap after hold released");
    slot(1, 0, 32'h6100, 0, 32'h0, 1, 1, 0, 0);
    recover(); idle(); idle();

    // Scoreboard drained
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R11 missing redirects: got %0d outstanding expected 0", expq.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule